// File: doc/BRIEF.md
# Configurable Serial Display Interface Controller

This block is the master side of a serial link to a small display panel. It takes one command at a time over a valid/busy handshake, lowers chip select and sends a frame. The frame holds an optional preamble, up to two control bits (a read/write flag and a register-select flag), and then one or more data words. A write burst pulls its words one at a time over a take strobe. A read burst returns each assembled word with a one-cycle valid pulse. The serial clock comes from a programmable divider of the system clock, and its idle level can be set to either polarity.

Four wiring modes are supported. The first is 3-wire, where one shared pin is built outside the block from the separate out, in and output-enable lines. The second is 4-wire, with separate in and out lines. The last two are 5-wire variants in which the register-select value leaves the serial stream and is driven on a line of its own. In one of these the line is meant to be sampled by the serial clock; in the other it is sampled by chip select. Settings are captured when a command is accepted, so a frame runs on one consistent configuration.

The sequencer has six states. IDLE moves to SETUP when a command is accepted. SETUP lasts one serial period and then goes to PRE, or to CTRL if the preamble length is zero, or to DATA if there are no control bits. PRE moves to CTRL or DATA after its last bit. CTRL moves to DATA. DATA loops once per word and goes to HOLD after the last bit of the last word. HOLD lasts one serial period and then returns to IDLE.

Top module: `sdi_ctrl`

## Requirements
- R1: After reset, and whenever no frame is running, `cs_n` is 1, `busy` is 0, `sd_oe` is 0 and `sclk` equals `cfg_cpol`.
- R2: A frame sends its bits in this order: the preamble, then the control bits, then the data words. The preamble is the low `cfg_pre_len` bits of `cfg_pre_bits`, starting with bit `cfg_pre_len-1`. A length of 0 omits the preamble. Each data word goes MSB first.
- R3: The read/write bit is 1 for a read. When `cfg_rs_first` is 1, the register-select bit comes before the read/write bit; when it is 0, the read/write bit comes first.
- R4: When `cfg_rw_en` is 0, the read/write bit is left out of the frame.
- R5: A command carries `cmd_len+1` words under one continuous low period of `cs_n`. A write command pulses `wr_take` once per word: once at acceptance and once after each word boundary. The word on `wr_data` is captured at acceptance and at each boundary. A read command never pulses `wr_take`.
- R6: Each bit lasts 2*(`cfg_div`+1) clocks. During the first half `sclk` is at its idle level, and during the second half it is at the active level. A frame of N bits gives N active edges, keeps `sclk` active for N*(`cfg_div`+1) clocks, and keeps `busy` high for (4+2N)*(`cfg_div`+1) clocks.
- R7: During a read, `sd_in` is sampled as `sclk` turns active. Each word appears on `rd_data` together with a one-cycle `rd_valid` pulse, with the first received bit as the MSB.
- R8: In mode 0 (3-wire), `sd_oe` is 1 while `cs_n` is low, except during the data bits of a read, where it is 0. During those read data bits `sd_out` is 0.
- R9: In mode 1 (4-wire), `sd_oe` stays 1 for the whole frame, read data included.
- R10: In mode 2 (5-wire, clock-sampled select), the register-select bit is left out of the stream. `rs_out` carries it during the data bits and is 0 during the preamble and control bits.
- R11: In mode 3 (5-wire, chip-select-sampled select), the register-select bit is left out of the stream. `rs_out` takes the command's value on acceptance and holds it through the frame and afterwards, until the next command.
- R12: A `cmd_valid` that arrives while `busy` is high is ignored. The running frame is unchanged, and no frame follows it.
- R13: In modes 0 and 1, `rs_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Wiring mode: 0 3-wire, 1 4-wire, 2 5-wire clock-sampled select, 3 5-wire chip-select-sampled select |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_pre_len | input | PL_W | Preamble length in bits, 0 to PRE_MAX |
| cfg_pre_bits | input | PRE_MAX | Preamble contents |
| cfg_rs_first | input | 1 | Sends register-select before read/write when 1 |
| cfg_rw_en | input | 1 | Includes the read/write bit when 1 |
| cfg_div | input | DIV_W | Half-bit length in clocks, minus one |
| cmd_valid | input | 1 | Command request |
| cmd_read | input | 1 | 1 for a read command |
| cmd_rs | input | 1 | Register-select value |
| cmd_len | input | LEN_W | Number of words minus one |
| wr_data | input | DW | Write word |
| wr_take | output | 1 | Pulse: write word captured |
| rd_data | output | DW | Last received word |
| rd_valid | output | 1 | Pulse: rd_data holds a new word |
| busy | output | 1 | Frame in progress |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for the shared data pin |
| sd_in | input | 1 | Serial data in |
| rs_out | output | 1 | Separate register-select line (5-wire modes) |

## Verification
The vectors cover a zero-length preamble, the full 16-bit preamble, both control-bit orders, a frame with no control bits, and the 16-word burst. Each of these catches a sequencer that takes the wrong exit from SETUP, PRE or CTRL: the captured bit stream shifts, and the active-edge count stops matching. The busy and active-clock cycle counts catch an off-by-one in the divider reload or in the SETUP and HOLD periods, and so does an inverted clock polarity. The 3-wire read checks that the output enable drops only during the data bits. Read-back words expose sampling on the wrong edge, which shifts the result by one bit. Two directed tests finish the set. A command pulsed in mid-frame must not restart or alter the frame. A reset in mid-frame must release chip select at once.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

    typedef enum logic [1:0] {
        WIRE3     = 2'd0,
        WIRE4     = 2'd1,
        WIRE5_CLK = 2'd2,
        WIRE5_CS  = 2'd3
    } sdi_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_PRE   = 3'd2,
        ST_CTRL  = 3'd3,
        ST_DATA  = 3'd4,
        ST_HOLD  = 3'd5
    } sdi_state_e;

endpackage

// File: rtl/sdi_tick_gen.sv
// Half-bit tick source: one tick every (div+1) clocks while run is high.
module sdi_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_l <= '0;
        end else if (load) begin
            cnt   <= div;
            div_l <= div;
        end else if (run) begin
            if (cnt == '0) begin
                cnt <= div_l;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign tick = run && (cnt == '0);

endmodule

// File: rtl/sdi_seq.sv
// Frame sequencer: walks SETUP, PRE, CTRL, DATA and HOLD in half-bit steps.
module sdi_seq
    import sdi_pkg::*;
#(
    parameter int DW      = 8,
    parameter int PRE_MAX = 16,
    parameter int LEN_W   = 4,
    parameter int PL_W    = $clog2(PRE_MAX + 1),
    parameter int CNT_W   = $clog2((PRE_MAX > DW) ? PRE_MAX : DW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic [PL_W-1:0]  pre_len,
    input  logic [1:0]       nctrl,
    input  logic [LEN_W-1:0] len,
    output sdi_state_e       state,
    output logic             half,
    output logic [CNT_W-1:0] cnt,
    output logic             ev_sample,
    output logic             ev_shift,
    output logic             ev_word_end,
    output logic             ev_next_word
);

    localparam logic [CNT_W-1:0] DATA_TOP = CNT_W'(DW - 1);

    sdi_state_e       state_d;
    logic             half_d;
    logic [CNT_W-1:0] cnt_d;
    logic [LEN_W-1:0] word, word_d;

    sdi_state_e       first_st, after_pre_st;
    logic [CNT_W-1:0] first_cnt, after_pre_cnt;

    // Entry points that skip empty phases
    always_comb begin
        if (nctrl != 2'd0) begin
            after_pre_st  = ST_CTRL;
            after_pre_cnt = CNT_W'(nctrl - 2'd1);
        end else begin
            after_pre_st  = ST_DATA;
            after_pre_cnt = DATA_TOP;
        end
        if (pre_len != '0) begin
            first_st  = ST_PRE;
            first_cnt = CNT_W'(pre_len - 1'b1);
        end else begin
            first_st  = after_pre_st;
            first_cnt = after_pre_cnt;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        half_d  = half;
        cnt_d   = cnt;
        word_d  = word;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SETUP;
                    half_d  = 1'b0;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    if (!half) begin
                        half_d = 1'b1;
                    end else begin
                        half_d  = 1'b0;
                        state_d = first_st;
                        cnt_d   = first_cnt;
                        word_d  = '0;
                    end
                end
            end
            ST_PRE: begin
                if (tick) begin
                    if (!half) begin
                        half_d = 1'b1;
                    end else begin
                        half_d = 1'b0;
                        if (cnt == '0) begin
                            state_d = after_pre_st;
                            cnt_d   = after_pre_cnt;
                        end else begin
                            cnt_d = cnt - 1'b1;
                        end
                    end
                end
            end
            ST_CTRL: begin
                if (tick) begin
                    if (!half) begin
                        half_d = 1'b1;
                    end else begin
                        half_d = 1'b0;
                        if (cnt == '0) begin
                            state_d = ST_DATA;
                            cnt_d   = DATA_TOP;
                        end else begin
                            cnt_d = cnt - 1'b1;
                        end
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (!half) begin
                        half_d = 1'b1;
                    end else begin
                        half_d = 1'b0;
                        if (cnt == '0) begin
                            if (word == len) begin
                                state_d = ST_HOLD;
                            end else begin
                                word_d = word + 1'b1;
                                cnt_d  = DATA_TOP;
                            end
                        end else begin
                            cnt_d = cnt - 1'b1;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (!half) begin
                        half_d = 1'b1;
                    end else begin
                        half_d  = 1'b0;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                half_d  = 1'b0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            half  <= 1'b0;
            cnt   <= '0;
            word  <= '0;
        end else begin
            state <= state_d;
            half  <= half_d;
            cnt   <= cnt_d;
            word  <= word_d;
        end
    end

    // Event strobes for the datapath
    always_comb begin
        ev_sample    = tick && !half && (state == ST_DATA);
        ev_shift     = tick &&  half && (state == ST_DATA) && (cnt != '0);
        ev_word_end  = tick &&  half && (state == ST_DATA) && (cnt == '0);
        ev_next_word = ev_word_end && (word != len);
    end

endmodule

// File: rtl/sdi_shift.sv
// Transmit and receive word registers, MSB first.
module sdi_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          shift,
    input  logic          sample,
    input  logic          sd_in,
    input  logic          word_done,
    output logic          tx_bit,
    output logic [DW-1:0] rx_word,
    output logic          rx_valid
);

    logic [DW-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (load) begin
                tx_q <= load_data;
            end else if (shift) begin
                tx_q <= {tx_q[DW-2:0], 1'b0};
            end
            if (sample) begin
                rx_word <= {rx_word[DW-2:0], sd_in};
            end
            rx_valid <= word_done;
        end
    end

    assign tx_bit = tx_q[DW-1];

endmodule

// File: rtl/sdi_ctrl.sv
// Serial display interface master: top level.
module sdi_ctrl
    import sdi_pkg::*;
#(
    parameter int DW      = 8,
    parameter int PRE_MAX = 16,
    parameter int DIV_W   = 8,
    parameter int LEN_W   = 4,
    parameter int PL_W    = $clog2(PRE_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_cpol,
    input  logic [PL_W-1:0]    cfg_pre_len,
    input  logic [PRE_MAX-1:0] cfg_pre_bits,
    input  logic               cfg_rs_first,
    input  logic               cfg_rw_en,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cmd_valid,
    input  logic               cmd_read,
    input  logic               cmd_rs,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic [DW-1:0]      wr_data,
    output logic               wr_take,
    output logic [DW-1:0]      rd_data,
    output logic               rd_valid,
    output logic               busy,
    output logic               cs_n,
    output logic               sclk,
    output logic               sd_out,
    output logic               sd_oe,
    input  logic               sd_in,
    output logic               rs_out
);

    localparam int CNT_W = $clog2((PRE_MAX > DW) ? PRE_MAX : DW);
    localparam int PI_W  = $clog2(PRE_MAX);

    sdi_state_e       state;
    logic             half;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             accept;
    logic             ev_sample, ev_shift, ev_word_end, ev_next_word;
    logic             tx_bit;
    logic             in_bits;
    logic             ctl_bit;

    // Frame settings captured at acceptance
    sdi_mode_e        mode_l;
    logic             cpol_l, rsf_l, rwen_l, read_l, rs_l;
    logic [PL_W-1:0]  plen_l;
    logic [PRE_MAX-1:0] pbits_l;
    logic [LEN_W-1:0] len_l;
    logic [1:0]       nctrl;
    logic             take_q;

    assign accept = cmd_valid && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_l  <= WIRE3;
            cpol_l  <= 1'b0;
            rsf_l   <= 1'b0;
            rwen_l  <= 1'b0;
            read_l  <= 1'b0;
            rs_l    <= 1'b0;
            plen_l  <= '0;
            pbits_l <= '0;
            len_l   <= '0;
        end else if (accept) begin
            mode_l  <= sdi_mode_e'(cfg_mode);
            cpol_l  <= cfg_cpol;
            rsf_l   <= cfg_rs_first;
            rwen_l  <= cfg_rw_en;
            read_l  <= cmd_read;
            rs_l    <= cmd_rs;
            plen_l  <= (cfg_pre_len > PL_W'(PRE_MAX)) ? PL_W'(PRE_MAX) : cfg_pre_len;
            pbits_l <= cfg_pre_bits;
            len_l   <= cmd_len;
        end
    end

    // Select travels in the stream only on 3- and 4-wire links
    assign nctrl = {1'b0, rwen_l} + {1'b0, (mode_l == WIRE3) || (mode_l == WIRE4)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_q <= 1'b0;
        end else begin
            take_q <= accept ? !cmd_read : (ev_next_word && !read_l);
        end
    end

    sdi_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .run   (state != ST_IDLE),
        .div   (cfg_div),
        .tick  (tick)
    );

    sdi_seq #(
        .DW      (DW),
        .PRE_MAX (PRE_MAX),
        .LEN_W   (LEN_W),
        .PL_W    (PL_W),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept),
        .tick         (tick),
        .pre_len      (plen_l),
        .nctrl        (nctrl),
        .len          (len_l),
        .state        (state),
        .half         (half),
        .cnt          (cnt),
        .ev_sample    (ev_sample),
        .ev_shift     (ev_shift),
        .ev_word_end  (ev_word_end),
        .ev_next_word (ev_next_word)
    );

    sdi_shift #(
        .DW (DW)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept || (ev_next_word && !read_l)),
        .load_data (wr_data),
        .shift     (ev_shift && !read_l),
        .sample    (ev_sample && read_l),
        .sd_in     (sd_in),
        .word_done (ev_word_end && read_l),
        .tx_bit    (tx_bit),
        .rx_word   (rd_data),
        .rx_valid  (rd_valid)
    );

    // Control-bit pick: with two bits, cnt==1 is the first one sent
    always_comb begin
        if (nctrl == 2'd2) begin
            if (cnt[0]) begin
                ctl_bit = rsf_l ? rs_l : read_l;
            end else begin
                ctl_bit = rsf_l ? read_l : rs_l;
            end
        end else begin
            ctl_bit = rwen_l ? read_l : rs_l;
        end
    end

    // Output decode
    always_comb begin
        in_bits = (state == ST_PRE) || (state == ST_CTRL) || (state == ST_DATA);
        cs_n    = (state == ST_IDLE);
        busy    = (state != ST_IDLE);
        wr_take = take_q;
        sclk    = (state == ST_IDLE) ? cfg_cpol : (cpol_l ^ (half && in_bits));
        unique case (state)
            ST_PRE:  sd_out = pbits_l[cnt[PI_W-1:0]];
            ST_CTRL: sd_out = ctl_bit;
            ST_DATA: sd_out = read_l ? 1'b0 : tx_bit;
            default: sd_out = 1'b0;
        endcase
        sd_oe = (state != ST_IDLE) &&
                !((mode_l == WIRE3) && read_l && (state == ST_DATA));
        unique case (mode_l)
            WIRE5_CLK: rs_out = (state == ST_DATA) && rs_l;
            WIRE5_CS:  rs_out = rs_l;
            default:   rs_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdi_ctrl_chk.sv
// Property checker, attached to every sdi_ctrl instance.
module sdi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       cfg_cpol,
    input logic       cmd_valid,
    input logic       busy,
    input logic       cs_n,
    input logic       sclk,
    input logic       sd_oe,
    input logic       rs_out,
    input logic       rd_valid,
    input logic       wr_take
);

    AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == cfg_cpol)); // R1

    AST_IDLE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sd_oe); // R8

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (busy && !cs_n)); // R12

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R7

    AST_RDV_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !cs_n); // R7

    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |=> !wr_take); // R5

    AST_OE_FOUR_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'd1) && !cs_n) |-> sd_oe); // R9

    AST_RS_HELD_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'd3) && !cs_n && $past(!cs_n)) |-> $stable(rs_out)); // R11

endmodule

bind sdi_ctrl sdi_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mode  (cfg_mode),
    .cfg_cpol  (cfg_cpol),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sd_oe     (sd_oe),
    .rs_out    (rs_out),
    .rd_valid  (rd_valid),
    .wr_take   (wr_take)
);

// File: tb/sdi_ctrl_bench.sv
module sdi_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    typedef struct packed {
        logic [1:0]  mode;
        logic        cpol;
        logic [4:0]  plen;
        logic [15:0] pbits;
        logic        rsf;
        logic        rwen;
        logic [7:0]  div;
        logic        rd;
        logic        rs;
        logic [3:0]  len;
        logic [7:0]  seed;
    } vec_t;

    // mode cpol plen pbits rsf rwen div rd rs len seed
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 5'd3,  16'h0005, 1'b0, 1'b1, 8'd1, 1'b0, 1'b1, 4'd0,  8'hA5},
        '{2'd0, 1'b1, 5'd0,  16'h0000, 1'b1, 1'b1, 8'd0, 1'b1, 1'b0, 4'd2,  8'h3C},
        '{2'd1, 1'b0, 5'd16, 16'hB38E, 1'b1, 1'b1, 8'd2, 1'b1, 1'b1, 4'd1,  8'h5A},
        '{2'd1, 1'b0, 5'd5,  16'h0013, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 4'd3,  8'h11},
        '{2'd2, 1'b0, 5'd2,  16'h0002, 1'b0, 1'b1, 8'd1, 1'b0, 1'b1, 4'd1,  8'hC3},
        '{2'd3, 1'b1, 5'd0,  16'h0000, 1'b0, 1'b1, 8'd0, 1'b1, 1'b1, 4'd0,  8'h77},
        '{2'd3, 1'b0, 5'd0,  16'h0000, 1'b0, 1'b0, 8'd3, 1'b0, 1'b1, 4'd0,  8'h0F},
        '{2'd0, 1'b0, 5'd1,  16'h0001, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0, 4'd15, 8'h99}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_cpol = 1'b0;
    logic [4:0]  cfg_pre_len = '0;
    logic [15:0] cfg_pre_bits = '0;
    logic        cfg_rs_first = 1'b0;
    logic        cfg_rw_en = 1'b1;
    logic [7:0]  cfg_div = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic        cmd_rs = 1'b0;
    logic [3:0]  cmd_len = '0;
    logic [7:0]  wr_data = '0;
    logic        sd_in = 1'b0;
    logic        wr_take, rd_valid, busy, cs_n, sclk, sd_out, sd_oe, rs_out;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    logic exp_b [256];
    logic rx_b  [256];
    logic cap_out [256];
    logic cap_oe  [256];
    logic cap_rs  [256];
    logic [7:0] rd_got [16];

    sdi_ctrl u_sdi_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cpol(cfg_cpol),
        .cfg_pre_len(cfg_pre_len), .cfg_pre_bits(cfg_pre_bits),
        .cfg_rs_first(cfg_rs_first), .cfg_rw_en(cfg_rw_en), .cfg_div(cfg_div),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_rs(cmd_rs),
        .cmd_len(cmd_len), .wr_data(wr_data), .wr_take(wr_take),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .cs_n(cs_n),
        .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
        .rs_out(rs_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] wword(input logic [7:0] s, input int k);
        return s + 8'(k * 29);
    endfunction

    function automatic logic [7:0] rword(input logic [7:0] s, input int k);
        return s ^ 8'(k * 83 + 7);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected stream and panel read stream from the requirements
    task automatic build(input vec_t v, output int n, output int hdr);
        int i;
        int nctl;
        i = 0;
        for (int p = int'(v.plen) - 1; p >= 0; p--) begin
            exp_b[i] = v.pbits[p];
            i++;
        end
        nctl = (v.rwen ? 1 : 0) + ((v.mode < 2'd2) ? 1 : 0);
        if (nctl == 2) begin
            exp_b[i]   = v.rsf ? v.rs : v.rd;
            exp_b[i+1] = v.rsf ? v.rd : v.rs;
        end else if (nctl == 1) begin
            exp_b[i] = v.rwen ? v.rd : v.rs;
        end
        i = i + nctl;
        hdr = i;
        for (int j = 0; j < 256; j++) rx_b[j] = 1'b0;
        for (int w = 0; w <= int'(v.len); w++) begin
            for (int b = 7; b >= 0; b--) begin
                logic [7:0] ww;
                logic [7:0] rw;
                ww = wword(v.seed, w);
                rw = rword(v.seed, w);
                exp_b[i] = v.rd ? 1'b0 : ww[b];
                rx_b[i]  = rw[b];
                i++;
            end
        end
        n = i;
    endtask

    task automatic run_frame(input vec_t v, input bit poke);
        int n, hdr, k, busy_cyc, act_cyc, ntake, nrd, cs_bad, oe_bad, rs_bad;
        int mism, first_bad;
        logic prev_s;
        build(v, n, hdr);
        cfg_mode = v.mode; cfg_cpol = v.cpol; cfg_pre_len = v.plen;
        cfg_pre_bits = v.pbits; cfg_rs_first = v.rsf; cfg_rw_en = v.rwen;
        cfg_div = v.div;
        wr_data = wword(v.seed, 0);
        sd_in = rx_b[0];
        @(negedge clk);
        cmd_read = v.rd; cmd_rs = v.rs; cmd_len = v.len; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        k = 0; busy_cyc = 0; act_cyc = 0; ntake = 0; nrd = 0;
        cs_bad = 0; oe_bad = 0; rs_bad = 0;
        prev_s = v.cpol;
        while (busy && busy_cyc < 20000) begin
            busy_cyc++;
            if (poke && busy_cyc == 5) begin
                cmd_valid = 1'b1; cmd_rs = ~v.rs; cmd_read = ~v.rd;
            end
            if (poke && busy_cyc == 6) cmd_valid = 1'b0;
            if (sclk != prev_s && sclk == ~v.cpol && k < 255) begin
                cap_out[k] = sd_out; cap_oe[k] = sd_oe; cap_rs[k] = rs_out;
                k++;
                sd_in = rx_b[k];
            end
            prev_s = sclk;
            if (sclk == ~v.cpol) act_cyc++;
            if (wr_take) begin
                ntake++;
                wr_data = wword(v.seed, ntake);
            end
            if (rd_valid && nrd < 16) begin
                rd_got[nrd] = rd_data;
                nrd++;
            end
            if (cs_n) cs_bad++;
            if (v.mode == 2'd1 && !sd_oe) oe_bad++;
            if (v.mode == 2'd3 && rs_out != v.rs) rs_bad++;
            @(negedge clk);
        end
        chk(k == n, "R6", "active edge count", k, n);
        chk(busy_cyc == (4 + 2*n) * (int'(v.div) + 1), "R6", "busy cycles",
            busy_cyc, (4 + 2*n) * (int'(v.div) + 1));
        chk(act_cyc == n * (int'(v.div) + 1), "R6", "active sclk cycles",
            act_cyc, n * (int'(v.div) + 1));
        mism = 0; first_bad = -1;
        for (int i = 0; i < n && i < k; i++) begin
            if (cap_out[i] !== exp_b[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        end
        chk(mism == 0, "R2 R3 R4", "stream mismatches (first bit index in log)",
            first_bad, -1);
        chk(cs_bad == 0, "R5", "cycles with cs_n high while busy", cs_bad, 0);
        chk(ntake == (v.rd ? 0 : int'(v.len) + 1), "R5", "wr_take pulses",
            ntake, v.rd ? 0 : int'(v.len) + 1);
        if (v.rd) begin
            chk(nrd == int'(v.len) + 1, "R7", "rd_valid pulses", nrd, int'(v.len) + 1);
            for (int w = 0; w < nrd; w++) begin
                chk(rd_got[w] == rword(v.seed, w), "R7", "read word",
                    int'(rd_got[w]), int'(rword(v.seed, w)));
            end
        end
        if (v.mode == 2'd0) begin
            oe_bad = 0;
            for (int i = 0; i < k; i++) begin
                if (cap_oe[i] !== !(v.rd && i >= hdr)) oe_bad++;
            end
            chk(oe_bad == 0, "R8", "3-wire oe errors", oe_bad, 0);
        end
        if (v.mode == 2'd1) chk(oe_bad == 0, "R9", "4-wire oe low cycles", oe_bad, 0);
        if (v.mode < 2'd2) begin
            rs_bad = 0;
            for (int i = 0; i < k; i++) if (cap_rs[i] !== 1'b0) rs_bad++;
            chk(rs_bad == 0, "R13", "rs_out high in 3/4-wire", rs_bad, 0);
        end
        if (v.mode == 2'd2) begin
            rs_bad = 0;
            for (int i = 0; i < k; i++) begin
                if (cap_rs[i] !== ((i >= hdr) ? v.rs : 1'b0)) rs_bad++;
            end
            chk(rs_bad == 0, "R10", "rs_out at clock edges", rs_bad, 0);
        end
        if (v.mode == 2'd3) begin
            chk(rs_bad == 0, "R11", "rs_out changes in frame", rs_bad, 0);
            chk(rs_out == v.rs, "R11", "rs_out held after frame", rs_out, v.rs);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1'b1 && busy == 1'b0, "R1", "cs_n/busy in reset", {cs_n, busy}, 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sd_oe == 1'b0 && sclk == cfg_cpol, "R1", "oe/sclk after reset",
            {sd_oe, sclk}, {1'b0, cfg_cpol});
        cfg_cpol = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R1", "idle sclk follows polarity", sclk, 1);

        for (int t = 0; t < NV; t++) begin
            run_frame(VECS[t], 1'b0);
            repeat (3) @(negedge clk);
        end

        // R12: command pulsed mid-frame is ignored
        run_frame(VECS[0], 1'b1);
        begin
            int extra;
            extra = 0;
            repeat (30) begin
                @(negedge clk);
                if (busy) extra++;
            end
            chk(extra == 0, "R12", "busy cycles after ignored command", extra, 0);
        end

        // R1: reset in mid-frame releases chip select
        cfg_mode = 2'd0; cfg_div = 8'd2; cfg_pre_len = 5'd4;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = 1'b0; cmd_len = 4'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0 && sd_oe == 1'b0, "R1",
            "state after mid-frame reset", {cs_n, busy, sd_oe}, 4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule